// File: doc/BRIEF.md
# Banked GPIO Controller with Interrupts

This block is a register-mapped general-purpose pin controller. It serves a parameterised number of banks, and each bank handles up to 32 pins. A bank may be narrower than 32 pins; its width is a build-time parameter. Each bank has eight 32-bit registers. Through them software sets the output level and the drive direction of each pin. Software also reads back the synchronised input level and chooses how each pin raises an interrupt.

A pin can trigger on one of these: a rising edge, a falling edge, either edge, a high level or a low level. An edge latches a status bit that stays set until software writes a one to that bit. A level trigger makes the status bit follow the qualified input level. All banks feed a single interrupt line. That line is high whenever an enabled status bit is set anywhere in the block.

Top module: `gpio_bank_top`

## Requirements
- R1: After reset, every in-range direction bit reads 1 (input) and all output-enable pins are low. The data-out, interrupt-enable, type, polarity, both-edge and status registers read 0, and the interrupt output is low.
- R2: Bank n occupies bytes n*32 to n*32+31. The byte offset selects the register within the bank: 0x00 synchronised input (read-only), 0x04 data out, 0x08 direction, 0x0C interrupt enable, 0x10 trigger type (1 = level), 0x14 polarity (1 = rising/high), 0x18 both-edge, 0x1C status. Read data appears one clock after the read strobe. An address above the last bank reads 0 and a write to it changes no register.
- R3: The pinOut slice of each bank equals its data-out register. A pin drives its output enable exactly when its direction bit is 0.
- R4: Bit positions at or above a bank's width read 0 in every register, ignore writes, and keep pinOut and pinOe low.
- R5: The input register returns the pin level after a two-flop synchroniser.
- R6: A pin with type 0 sets a sticky status bit when its synchronised input changes in the selected direction. With both-edge set, either direction sets it; otherwise polarity 1 selects rising and polarity 0 selects falling. Writing 1 to the status bit clears it. The interrupt output rises on the third clock edge after the pin changes.
- R7: For a pin with type 1, the status bit follows the synchronised level qualified by polarity (1 = high active, 0 = low active). Writing 1 to clear has no effect while that level holds.
- R8: The interrupt output is high exactly when some status bit and its enable bit are both 1 in any bank. Status bits still record events while their enable bit is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| busAddr | input | ADDR_W | Byte address of the access |
| busWr | input | 1 | Write strobe |
| busRd | input | 1 | Read strobe |
| busWdata | input | 32 | Write data |
| busRdata | output | 32 | Read data, valid the cycle after busRd |
| pinIn | input | NUM_BANKS*32 | Raw pin levels, 32 slots per bank |
| pinOut | output | NUM_BANKS*32 | Output levels |
| pinOe | output | NUM_BANKS*32 | Output enables |
| irqOut | output | 1 | Shared interrupt |

## Verification
The assertions check on every cycle that:
- an out-of-range address never raises a bank hit and reads back as zero;
- output enables above a bank's width stay low;
- an edge-mode status bit can only fall after a clear write or a type change;
- the interrupt is silent while no enable bit is set.

Some behaviour only the bench scenarios can show. These are the exact three-edge latency from a pin change to the interrupt, and which edge each polarity and both-edge setting accepts. They also include a level-mode bit that refuses to clear and then drops with the pin, and the masking of the narrow last bank. Random writes and read-backs of data-out, direction and enable registers, compared against a bench model, cover the register map and the pin ports.

// File: rtl/gpio_bank_pkg.sv
package gpio_bank_pkg;
  localparam int REG_W      = 32;
  localparam int BANK_SEL_W = 4;

  typedef enum logic [2:0] {
    REG_DIN  = 3'd0,
    REG_DOUT = 3'd1,
    REG_DIR  = 3'd2,
    REG_IE   = 3'd3,
    REG_TYPE = 3'd4,
    REG_POL  = 3'd5,
    REG_BOTH = 3'd6,
    REG_STAT = 3'd7
  } regSel_e;

  typedef struct packed {
    logic                  wr;
    logic                  rd;
    logic                  hit;
    logic [BANK_SEL_W-1:0] bank;
    regSel_e               regSel;
    logic [REG_W-1:0]      wdata;
  } busStrobe_t;

  function automatic logic [REG_W-1:0] widthMask(int w);
    logic [REG_W-1:0] m;
    for (int i = 0; i < REG_W; i++) m[i] = (i < w);
    return m;
  endfunction
endpackage

// File: rtl/gpio_bank_ctrl.sv
module gpio_bank_ctrl
  import gpio_bank_pkg::*;
#(
  parameter int NUM_BANKS = 4,
  parameter int ADDR_W    = 8
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [ADDR_W-1:0] busAddr,
  input  logic              busWr,
  input  logic              busRd,
  input  logic [REG_W-1:0]  busWdata,
  output busStrobe_t        stb
);
  localparam int IDX_W = ADDR_W - 5;

  logic [IDX_W-1:0] bankIdx;
  logic [1:0]       unusedAddrBits;

  assign bankIdx        = busAddr[ADDR_W-1:5];
  assign unusedAddrBits = busAddr[1:0];

  always_comb begin
    stb.wr     = busWr;
    stb.rd     = busRd;
    stb.hit    = (int'(bankIdx) < NUM_BANKS);
    stb.bank   = BANK_SEL_W'(bankIdx);
    stb.regSel = regSel_e'(busAddr[4:2]);
    stb.wdata  = busWdata;
  end

  // R2: addresses past the last bank never select a bank
  a_r2_oob_no_hit: assert property (@(posedge clk) disable iff (!rstN)
    (int'(busAddr) >= NUM_BANKS * 32) |-> !stb.hit);
endmodule

// File: rtl/gpio_bank_trig.sv
module gpio_bank_trig
  import gpio_bank_pkg::*;
#(
  parameter int WIDTH = 32
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic [REG_W-1:0] pinRaw,
  input  logic [REG_W-1:0] typeR,
  input  logic [REG_W-1:0] polR,
  input  logic [REG_W-1:0] bothR,
  input  logic [REG_W-1:0] clrBits,
  input  logic             typeWr,
  output logic [REG_W-1:0] syncOut,
  output logic [REG_W-1:0] status
);
  localparam logic [REG_W-1:0] MASK = widthMask(WIDTH);

  logic [REG_W-1:0] syncA, syncB, prevB;
  logic [REG_W-1:0] riseEv, fallEv, edgeEv, levelAct, statusNext;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      syncA  <= '0;
      syncB  <= '0;
      prevB  <= '0;
      status <= '0;
    end else begin
      syncA  <= pinRaw & MASK;
      syncB  <= syncA;
      prevB  <= syncB;
      status <= statusNext;
    end
  end

  always_comb begin
    riseEv     = syncB & ~prevB;
    fallEv     = ~syncB & prevB;
    edgeEv     = (riseEv & (polR | bothR)) | (fallEv & (~polR | bothR));
    levelAct   = (syncB & polR) | (~syncB & ~polR);
    statusNext = ((typeR & levelAct) | (~typeR & ((status & ~clrBits) | edgeEv))) & MASK;
  end

  assign syncOut = syncB;

  // R6: an edge-mode status bit only falls after a clear or a type change
  a_r6_edge_sticky: assert property (@(posedge clk) disable iff (!rstN)
    (clrBits == '0 && !typeWr) |=> ((status & $past(status & ~typeR)) == $past(status & ~typeR)));
endmodule

// File: rtl/gpio_bank_datapath.sv
module gpio_bank_datapath
  import gpio_bank_pkg::*;
#(
  parameter int                      NUM_BANKS   = 4,
  parameter logic [NUM_BANKS*6-1:0]  BANK_WIDTHS = {6'd24, 6'd32, 6'd32, 6'd32}
) (
  input  logic                         clk,
  input  logic                         rstN,
  input  busStrobe_t                   stb,
  input  logic [NUM_BANKS*REG_W-1:0]   pinIn,
  output logic [NUM_BANKS*REG_W-1:0]   pinOut,
  output logic [NUM_BANKS*REG_W-1:0]   pinOe,
  output logic [REG_W-1:0]             busRdata,
  output logic                         irqOut
);
  localparam int FLAT_W = NUM_BANKS * REG_W;

  logic [FLAT_W-1:0] bankRdFlat;
  logic [FLAT_W-1:0] pendFlat;
  logic [FLAT_W-1:0] ieFlat;
  logic [FLAT_W-1:0] maskFlat;

  for (genvar b = 0; b < NUM_BANKS; b++) begin : g_bank
    localparam int               BW   = int'(BANK_WIDTHS[b*6 +: 6]);
    localparam logic [REG_W-1:0] MASK = widthMask(BW);

    logic [REG_W-1:0] doutR, dirR, ieR, typeR, polR, bothR;
    logic [REG_W-1:0] syncV, statV, clrBits, rdV;
    logic             wrThis, typeWr;

    assign wrThis  = stb.wr && stb.hit && (stb.bank == BANK_SEL_W'(b));
    assign clrBits = (wrThis && stb.regSel == REG_STAT) ? (stb.wdata & MASK) : '0;
    assign typeWr  = wrThis && stb.regSel == REG_TYPE;

    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN) begin
        doutR <= '0;
        dirR  <= MASK;
        ieR   <= '0;
        typeR <= '0;
        polR  <= '0;
        bothR <= '0;
      end else if (wrThis) begin
        case (stb.regSel)
          REG_DOUT: doutR <= stb.wdata & MASK;
          REG_DIR:  dirR  <= stb.wdata & MASK;
          REG_IE:   ieR   <= stb.wdata & MASK;
          REG_TYPE: typeR <= stb.wdata & MASK;
          REG_POL:  polR  <= stb.wdata & MASK;
          REG_BOTH: bothR <= stb.wdata & MASK;
          default:  ;
        endcase
      end
    end

    gpio_bank_trig #(.WIDTH(BW)) trig_i (
      .clk     (clk),
      .rstN    (rstN),
      .pinRaw  (pinIn[b*REG_W +: REG_W]),
      .typeR   (typeR),
      .polR    (polR),
      .bothR   (bothR),
      .clrBits (clrBits),
      .typeWr  (typeWr),
      .syncOut (syncV),
      .status  (statV)
    );

    always_comb begin
      case (stb.regSel)
        REG_DIN:  rdV = syncV;
        REG_DOUT: rdV = doutR;
        REG_DIR:  rdV = dirR;
        REG_IE:   rdV = ieR;
        REG_TYPE: rdV = typeR;
        REG_POL:  rdV = polR;
        REG_BOTH: rdV = bothR;
        default:  rdV = statV;
      endcase
    end

    assign bankRdFlat[b*REG_W +: REG_W] = rdV;
    assign pendFlat[b*REG_W +: REG_W]   = statV & ieR;
    assign ieFlat[b*REG_W +: REG_W]     = ieR;
    assign maskFlat[b*REG_W +: REG_W]   = MASK;
    assign pinOut[b*REG_W +: REG_W]     = doutR;
    assign pinOe[b*REG_W +: REG_W]      = ~dirR & MASK;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) busRdata <= '0;
    else if (stb.rd) busRdata <= stb.hit ? bankRdFlat[stb.bank*REG_W +: REG_W] : '0;
  end

  assign irqOut = |pendFlat;

  // R2: a read outside the banks returns zero on the next cycle
  a_r2_oob_reads_zero: assert property (@(posedge clk) disable iff (!rstN)
    (stb.rd && !stb.hit) |=> (busRdata == '0));

  // R4: output enables above a bank's width never rise
  a_r4_oe_in_width: assert property (@(posedge clk) disable iff (!rstN)
    ((pinOe & ~maskFlat) == '0) && ((pinOut & ~maskFlat) == '0));

  // R8: no interrupt while every enable bit is clear
  a_r8_irq_needs_enable: assert property (@(posedge clk) disable iff (!rstN)
    (ieFlat == '0) |-> !irqOut);
endmodule

// File: rtl/gpio_bank_top.sv
module gpio_bank_top
  import gpio_bank_pkg::*;
#(
  parameter int                     NUM_BANKS   = 4,
  parameter logic [NUM_BANKS*6-1:0] BANK_WIDTHS = {6'd24, 6'd32, 6'd32, 6'd32},
  parameter int                     ADDR_W      = 8
) (
  input  logic                        clk,
  input  logic                        rstN,
  input  logic [ADDR_W-1:0]           busAddr,
  input  logic                        busWr,
  input  logic                        busRd,
  input  logic [31:0]                 busWdata,
  output logic [31:0]                 busRdata,
  input  logic [NUM_BANKS*32-1:0]     pinIn,
  output logic [NUM_BANKS*32-1:0]     pinOut,
  output logic [NUM_BANKS*32-1:0]     pinOe,
  output logic                        irqOut
);
  busStrobe_t stb;

  gpio_bank_ctrl #(.NUM_BANKS(NUM_BANKS), .ADDR_W(ADDR_W)) ctrl_i (
    .clk      (clk),
    .rstN     (rstN),
    .busAddr  (busAddr),
    .busWr    (busWr),
    .busRd    (busRd),
    .busWdata (busWdata),
    .stb      (stb)
  );

  gpio_bank_datapath #(.NUM_BANKS(NUM_BANKS), .BANK_WIDTHS(BANK_WIDTHS)) dp_i (
    .clk      (clk),
    .rstN     (rstN),
    .stb      (stb),
    .pinIn    (pinIn),
    .pinOut   (pinOut),
    .pinOe    (pinOe),
    .busRdata (busRdata),
    .irqOut   (irqOut)
  );
endmodule

// File: tb/gpio_bank_top_tb.sv
module gpio_bank_top_tb_top;
  localparam int NB = 4;
  localparam int BW [NB] = '{32, 32, 32, 24};

  logic           clk = 1'b0;
  logic           rstN = 1'b0;
  logic [7:0]     busAddr = '0;
  logic           busWr = 1'b0;
  logic           busRd = 1'b0;
  logic [31:0]    busWdata = '0;
  logic [31:0]    busRdata;
  logic [NB*32-1:0] pinIn = '0;
  logic [NB*32-1:0] pinOut;
  logic [NB*32-1:0] pinOe;
  logic           irqOut;

  int checks = 0;
  int fails = 0;
  bit done = 0;

  always #5 clk = ~clk;

  gpio_bank_top dut_i (
    .clk(clk), .rstN(rstN), .busAddr(busAddr), .busWr(busWr), .busRd(busRd),
    .busWdata(busWdata), .busRdata(busRdata), .pinIn(pinIn), .pinOut(pinOut),
    .pinOe(pinOe), .irqOut(irqOut)
  );

  function automatic logic [31:0] bmask(int b);
    return (BW[b] >= 32) ? 32'hFFFF_FFFF : ((32'd1 << BW[b]) - 32'd1);
  endfunction

  function automatic logic [7:0] ra(int b, int r);
    return 8'(b * 32 + r * 4);
  endfunction

  task automatic check(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [7:0] a, input logic [31:0] d);
    @(negedge clk);
    busAddr = a; busWdata = d; busWr = 1'b1;
    @(negedge clk);
    busWr = 1'b0;
  endtask

  task automatic rd(input logic [7:0] a, output logic [31:0] d);
    @(negedge clk);
    busAddr = a; busRd = 1'b1;
    @(negedge clk);
    busRd = 1'b0;
    d = busRdata;
  endtask

  task automatic rdCheck(input logic [7:0] a, input logic [31:0] exp, input string tag);
    logic [31:0] v;
    rd(a, v);
    check(v === exp, tag, v, exp);
  endtask

  task automatic waitCyc(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic clearAllStatus();
    for (int b = 0; b < NB; b++) wr(ra(b, 7), 32'hFFFF_FFFF);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      checks++; fails++;
      $display("FAIL watchdog expired");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  initial begin
    logic [31:0] model [NB][3];
    logic [31:0] v;
    int unsigned seedDummy;
    seedDummy = $urandom(32'd2015);

    waitCyc(3);
    rstN = 1'b1;
    waitCyc(1);

    // R1 reset state
    check(pinOe === '0, "R1 pinOe reset", pinOe[31:0], 32'h0);
    check(pinOut === '0, "R1 pinOut reset", pinOut[31:0], 32'h0);
    check(irqOut === 1'b0, "R1 irq reset", {31'd0, irqOut}, 32'h0);
    for (int b = 0; b < NB; b++) begin
      rdCheck(ra(b, 2), bmask(b), "R1 dir reset");
      rdCheck(ra(b, 1), 32'h0, "R1 dout reset");
      rdCheck(ra(b, 7), 32'h0, "R1 status reset");
      model[b][0] = 32'h0; model[b][1] = bmask(b); model[b][2] = 32'h0;
    end

    // R2 R3 random register traffic against a model
    for (int i = 0; i < 60; i++) begin
      int b = int'($urandom_range(NB - 1));
      int k = int'($urandom_range(2));
      logic [31:0] d = $urandom;
      wr(ra(b, k + 1), d);
      model[b][k] = d & bmask(b);
      rdCheck(ra(b, k + 1), model[b][k], "R2 register readback");
      check(pinOut[b*32 +: 32] === model[b][0], "R3 pinOut", pinOut[b*32 +: 32], model[b][0]);
      check(pinOe[b*32 +: 32] === (~model[b][1] & bmask(b)), "R3 pinOe",
            pinOe[b*32 +: 32], ~model[b][1] & bmask(b));
    end
    for (int b = 0; b < NB; b++) begin
      wr(ra(b, 3), 32'h0);
      wr(ra(b, 2), 32'hFFFF_FFFF);
      wr(ra(b, 1), 32'h0);
    end

    // R4 narrow last bank
    wr(ra(3, 1), 32'hFFFF_FFFF);
    rdCheck(ra(3, 1), 32'h00FF_FFFF, "R4 dout upper bits");
    check(pinOut[127:120] === 8'h0, "R4 pinOut upper", {24'd0, pinOut[127:120]}, 32'h0);
    wr(ra(3, 2), 32'h0);
    check(pinOe[127:120] === 8'h0, "R4 pinOe upper", {24'd0, pinOe[127:120]}, 32'h0);
    check(pinOe[119:96] === 24'hFF_FFFF, "R3 pinOe lower", {8'd0, pinOe[119:96]}, 32'h00FF_FFFF);
    rdCheck(ra(3, 2), 32'h0, "R4 dir readback");
    wr(ra(3, 2), 32'hFFFF_FFFF);
    wr(ra(3, 1), 32'h0);

    // R5 synchronised input
    for (int i = 0; i < 3; i++) begin
      @(negedge clk);
      pinIn = {$urandom, $urandom, $urandom, $urandom};
      waitCyc(3);
      for (int b = 0; b < NB; b++)
        rdCheck(ra(b, 0), pinIn[b*32 +: 32] & bmask(b), "R5 data in");
    end
    @(negedge clk);
    pinIn = '0;
    waitCyc(4);
    clearAllStatus();
    for (int b = 0; b < NB; b++) rdCheck(ra(b, 7), 32'h0, "R6 status cleared");

    // R6 rising edge on bank 1 pin 5, with R8 latency
    wr(ra(1, 5), 32'h20);
    wr(ra(1, 3), 32'h20);
    @(negedge clk);
    pinIn[37] = 1'b1;
    @(posedge clk); @(posedge clk); @(negedge clk);
    check(irqOut === 1'b0, "R6 irq not yet", {31'd0, irqOut}, 32'h0);
    @(negedge clk);
    check(irqOut === 1'b1, "R6 irq on third edge", {31'd0, irqOut}, 32'h1);
    rdCheck(ra(1, 7), 32'h20, "R6 rising status");
    @(negedge clk); pinIn[37] = 1'b0;
    waitCyc(4);
    rdCheck(ra(1, 7), 32'h20, "R6 sticky after fall");
    wr(ra(1, 7), 32'h20);
    rdCheck(ra(1, 7), 32'h0, "R6 w1c clears");
    check(irqOut === 1'b0, "R8 irq drops", {31'd0, irqOut}, 32'h0);

    // R6 falling only
    wr(ra(1, 5), 32'h0);
    @(negedge clk); pinIn[37] = 1'b1;
    waitCyc(4);
    rdCheck(ra(1, 7), 32'h0, "R6 falling ignores rise");
    @(negedge clk); pinIn[37] = 1'b0;
    waitCyc(4);
    rdCheck(ra(1, 7), 32'h20, "R6 falling status");
    wr(ra(1, 7), 32'h20);

    // R6 both edges
    wr(ra(1, 6), 32'h20);
    @(negedge clk); pinIn[37] = 1'b1;
    waitCyc(4);
    rdCheck(ra(1, 7), 32'h20, "R6 both rise");
    wr(ra(1, 7), 32'h20);
    @(negedge clk); pinIn[37] = 1'b0;
    waitCyc(4);
    rdCheck(ra(1, 7), 32'h20, "R6 both fall");
    wr(ra(1, 7), 32'h20);
    wr(ra(1, 6), 32'h0);

    // R8 status recorded while disabled
    wr(ra(1, 3), 32'h0);
    @(negedge clk); pinIn[37] = 1'b1;
    waitCyc(4);
    @(negedge clk); pinIn[37] = 1'b0;
    waitCyc(4);
    check(irqOut === 1'b0, "R8 masked irq", {31'd0, irqOut}, 32'h0);
    rdCheck(ra(1, 7), 32'h20, "R8 status while disabled");
    wr(ra(1, 3), 32'h20);
    check(irqOut === 1'b1, "R8 enable exposes pending", {31'd0, irqOut}, 32'h1);
    wr(ra(1, 7), 32'h20);
    wr(ra(1, 3), 32'h0);

    // R7 level high on bank 2 pin 0
    wr(ra(2, 5), 32'h1);
    wr(ra(2, 4), 32'h1);
    wr(ra(2, 3), 32'h1);
    rdCheck(ra(2, 7), 32'h0, "R7 level inactive");
    @(negedge clk); pinIn[64] = 1'b1;
    waitCyc(3);
    check(irqOut === 1'b1, "R7 level irq", {31'd0, irqOut}, 32'h1);
    wr(ra(2, 7), 32'h1);
    rdCheck(ra(2, 7), 32'h1, "R7 clear ignored while high");
    @(negedge clk); pinIn[64] = 1'b0;
    waitCyc(3);
    rdCheck(ra(2, 7), 32'h0, "R7 follows level low");
    check(irqOut === 1'b0, "R7 irq drops", {31'd0, irqOut}, 32'h0);
    wr(ra(2, 5), 32'h0);
    waitCyc(2);
    rdCheck(ra(2, 7), 32'h1, "R7 low-active level");
    wr(ra(2, 3), 32'h0);
    wr(ra(2, 4), 32'h0);
    wr(ra(2, 7), 32'h1);

    // R2 out-of-range accesses
    wr(ra(0, 1), 32'h1234_5678);
    wr(8'h80, 32'hFFFF_FFFF);
    wr(8'hE4, 32'hFFFF_FFFF);
    rdCheck(8'h80, 32'h0, "R2 oob read");
    rdCheck(8'hE4, 32'h0, "R2 oob read high");
    rdCheck(ra(0, 1), 32'h1234_5678, "R2 oob write ignored");
    rdCheck(ra(0, 3), 32'h0, "R2 oob write no enable");
    check(irqOut === 1'b0, "R2 oob no irq", {31'd0, irqOut}, 32'h0);

    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule